// File: doc/BRIEF.md
# Configuration Fuse Store with Read Lock

This block keeps the whole configuration image of a small programmable logic device in one flat memory of 2194 numbered fuse bits. After an erase, the image is shifted in one bit per clock. An internal address counter chooses where each bit goes. The block drives the stored image out as typed fields that the array logic beside it decodes: the product-term matrix, per-cell polarity and direction bits, per-term disable bits, two global mode bits and a 64-bit user identifier.

A test or programming agent can read any fuse back by address. Once the read lock is set, reads of configuration fuses return zero and raise a refusal pulse. The user identifier stays readable in every case. The lock can be removed only by an erase, which clears the whole image at once. While bits are loaded, a 16-bit checksum accumulates. It is complete once the last fuse has been written.

Top module: `fusemap_cfg_store`

## Requirements
- R1: After reset, every stored fuse, every decoded field, the load address, the checksum, the read data and the refusal flag are 0, and the lock is clear.
- R2: A cycle with `load_en_i` high and no erase writes `load_bit_i` to the fuse at the load address and advances the address by one. Once the address equals 2194, further load cycles change nothing.
- R3: Product-term row r (0..63) occupies fuses 32r..32r+31, and fuse n < 2048 appears on `and_fuses_o[n]`. `cell_pol_o[i]` is fuse 2048+i, `user_id_o[k]` is fuse 2056+k, `cell_dir_o[i]` is fuse 2120+i and `term_off_o[r]` is fuse 2128+r. `global_mode_o[0]` is fuse 2192 and `global_mode_o[1]` is fuse 2193.
- R4: A read request presents the fuse value at `rd_addr_i` on `rd_data_o` one cycle later, as it stood before that clock edge. An address of 2194 or more reads as 0 and is not refused.
- R5: `lock_i` sets the lock, seen on `secured_o` one cycle later. The lock then stays set until an erase or reset.
- R6: While the lock is set, a read of a fuse below 2056 or in 2120..2193 returns 0 and drives `rd_denied_o` high for exactly the one cycle in which that read's data appears.
- R7: Reads of fuses 2056..2119 (the user identifier) are never refused and always return the stored value.
- R8: `checksum_o` is the sum modulo 2^16 of 16-bit words, where bit j of word k is fuse 16k+j; the final word holds only fuses 2192 and 2193. It is updated one cycle after each loaded bit, and `load_done_o` is high exactly when the load address equals 2194. An image of all ones gives 16'hFF7A.
- R9: An erase clears all fuses, the lock, the checksum and the load address in one cycle. It wins over a load or a lock request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; models a blank part |
| erase_i | input | 1 | Clear image, lock, checksum and load address |
| load_en_i | input | 1 | Load one bit this cycle |
| load_bit_i | input | 1 | Bit value to load |
| lock_i | input | 1 | Set the read lock |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 12 | Fuse number to read |
| load_addr_o | output | 12 | Next fuse to be loaded |
| load_done_o | output | 1 | Whole image loaded; checksum final |
| checksum_o | output | 16 | Running word-sum checksum |
| rd_data_o | output | 1 | Read result |
| rd_denied_o | output | 1 | Read refused by the lock |
| secured_o | output | 1 | Lock state |
| and_fuses_o | output | 2048 | Product-term matrix, row-major |
| cell_pol_o | output | 8 | Per-cell output polarity |
| cell_dir_o | output | 8 | Per-cell direction/input select |
| term_off_o | output | 64 | Per-term disable |
| global_mode_o | output | 2 | Two global mode bits |
| user_id_o | output | 64 | User identifier |

## Verification
The hardest situations to reach are the ones where commands collide. One is an erase that arrives in the same cycle as a lock request and a load bit. Another is a lock set halfway through a load, after which loading must go on while reads are refused. A third is the checksum of the short final word, which only forms after all 2194 bits are in. The stimulus loads full images with several bit patterns, including all ones. It sets the lock both after and during a load. It sweeps reads across every field boundary and past the end of the map. It drives erase, lock and load together in one cycle. A behavioural model updated on every edge compares all outputs every cycle.

// File: rtl/fusecfg_pkg.sv
package fusecfg_pkg;

   // Classes of fuse address used by the read protection
   typedef enum logic [1:0] {
      FZ_CONFIG = 2'd0,
      FZ_IDENT  = 2'd1,
      FZ_NONE   = 2'd2
   } fuse_zone_e;

   function automatic fuse_zone_e zone_of(input int unsigned addr,
                                          input int unsigned id_lo,
                                          input int unsigned id_hi,
                                          input int unsigned total);
      if (addr >= total)                      return FZ_NONE;
      else if (addr >= id_lo && addr < id_hi) return FZ_IDENT;
      else                                    return FZ_CONFIG;
   endfunction

endpackage

// File: rtl/fuse_store.sv
module fuse_store #(
   parameter int TOTAL = 2194,
   parameter int AW    = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             erase_i,
   input  logic             we_i,
   input  logic [AW-1:0]    waddr_i,
   input  logic             wdata_i,
   output logic [TOTAL-1:0] fuses_o
);

   localparam logic [AW-1:0] LIMIT = AW'(TOTAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fuses_o <= '0;
      else if (erase_i)
         fuses_o <= '0;
      else if (we_i && (waddr_i < LIMIT))
         fuses_o[waddr_i] <= wdata_i;
   end

   // R9
   erase_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_i |=> (fuses_o == '0));

endmodule

// File: rtl/fuse_load_ctrl.sv
module fuse_load_ctrl #(
   parameter int TOTAL = 2194,
   parameter int AW    = 12,
   parameter int CW    = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          erase_i,
   input  logic          load_en_i,
   input  logic          load_bit_i,
   output logic          we_o,
   output logic          wbit_o,
   output logic [AW-1:0] addr_o,
   output logic          done_o,
   output logic [CW-1:0] checksum_o
);

   localparam int            SW    = $clog2(CW);
   localparam logic [AW-1:0] LIMIT = AW'(TOTAL);

   logic [CW-1:0] bit_weight;

   assign done_o     = (addr_o == LIMIT);
   assign we_o       = load_en_i && !erase_i && !done_o;
   assign wbit_o     = load_bit_i;
   assign bit_weight = CW'(load_bit_i) << addr_o[SW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o     <= '0;
         checksum_o <= '0;
      end else if (erase_i) begin
         addr_o     <= '0;
         checksum_o <= '0;
      end else if (we_o) begin
         addr_o     <= addr_o + 1'b1;
         checksum_o <= checksum_o + bit_weight;
      end
   end

   // R2
   addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_o <= LIMIT);

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en_i && !erase_i && (addr_o < LIMIT)) |=> (addr_o == $past(addr_o) + 1'b1));

   // R8
   csum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en_i && !erase_i) |=> $stable(checksum_o));

endmodule

// File: rtl/fuse_read_port.sv
module fuse_read_port
   import fusecfg_pkg::*;
#(
   parameter int TOTAL      = 2194,
   parameter int AW         = 12,
   parameter int ID_LO      = 2056,
   parameter int ID_HI      = 2120,
   parameter bit ID_IS_OPEN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en_i,
   input  logic [AW-1:0]    rd_addr_i,
   input  logic [TOTAL-1:0] fuses_i,
   input  logic             secured_i,
   output logic             rd_data_o,
   output logic             rd_denied_o
);

   localparam logic [AW-1:0] LIMIT = AW'(TOTAL);

   fuse_zone_e zone;
   logic       guarded;
   logic       raw_bit;

   assign zone    = zone_of(int'(rd_addr_i), ID_LO, ID_HI, TOTAL);
   assign raw_bit = (rd_addr_i < LIMIT) ? fuses_i[rd_addr_i] : 1'b0;

   generate
      if (ID_IS_OPEN) begin : g_id_open
         assign guarded = secured_i && (zone == FZ_CONFIG);
      end else begin : g_id_closed
         assign guarded = secured_i && (zone != FZ_NONE);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_o   <= 1'b0;
         rd_denied_o <= 1'b0;
      end else begin
         rd_denied_o <= rd_en_i && guarded;
         if (rd_en_i)
            rd_data_o <= guarded ? 1'b0 : raw_bit;
      end
   end

   // R6
   denied_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_denied_o |-> !rd_data_o);

   // R6
   denied_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_denied_o |-> ($past(secured_i) && $past(rd_en_i)));

   generate
      if (ID_IS_OPEN) begin : g_id_chk
         // R7
         id_never_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en_i && (zone == FZ_IDENT)) |=> !rd_denied_o);
      end
   endgenerate

endmodule

// File: rtl/fusemap_cfg_store.sv
module fusemap_cfg_store #(
   parameter int ROWS    = 64,
   parameter int COLS    = 32,
   parameter int CELLS   = 8,
   parameter int ID_BITS = 64,
   parameter int CSUM_W  = 16,
   parameter int AW      = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 erase_i,
   input  logic                 load_en_i,
   input  logic                 load_bit_i,
   input  logic                 lock_i,
   input  logic                 rd_en_i,
   input  logic [AW-1:0]        rd_addr_i,
   output logic [AW-1:0]        load_addr_o,
   output logic                 load_done_o,
   output logic [CSUM_W-1:0]    checksum_o,
   output logic                 rd_data_o,
   output logic                 rd_denied_o,
   output logic                 secured_o,
   output logic [ROWS*COLS-1:0] and_fuses_o,
   output logic [CELLS-1:0]     cell_pol_o,
   output logic [CELLS-1:0]     cell_dir_o,
   output logic [ROWS-1:0]      term_off_o,
   output logic [1:0]           global_mode_o,
   output logic [ID_BITS-1:0]   user_id_o
);

   localparam int POL_BASE  = ROWS * COLS;
   localparam int ID_BASE   = POL_BASE + CELLS;
   localparam int DIR_BASE  = ID_BASE + ID_BITS;
   localparam int OFF_BASE  = DIR_BASE + CELLS;
   localparam int MODE_BASE = OFF_BASE + ROWS;
   localparam int TOTAL     = MODE_BASE + 2;

   generate
      if (TOTAL >= (1 << AW)) begin : g_bad_aw
         $error("fusemap_cfg_store: AW too narrow for the fuse count");
      end
      if ((1 << $clog2(CSUM_W)) != CSUM_W) begin : g_bad_csum
         $error("fusemap_cfg_store: CSUM_W must be a power of two");
      end
      if (ROWS < 1 || COLS < 1 || CELLS < 1 || ID_BITS < 1) begin : g_bad_dim
         $error("fusemap_cfg_store: field sizes must be positive");
      end
   endgenerate

   logic [TOTAL-1:0] fuses;
   logic             we;
   logic             wbit;

   fuse_load_ctrl #(.TOTAL(TOTAL), .AW(AW), .CW(CSUM_W)) u_load (
      .clk        (clk),
      .rst_n      (rst_n),
      .erase_i    (erase_i),
      .load_en_i  (load_en_i),
      .load_bit_i (load_bit_i),
      .we_o       (we),
      .wbit_o     (wbit),
      .addr_o     (load_addr_o),
      .done_o     (load_done_o),
      .checksum_o (checksum_o)
   );

   fuse_store #(.TOTAL(TOTAL), .AW(AW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .erase_i (erase_i),
      .we_i    (we),
      .waddr_i (load_addr_o),
      .wdata_i (wbit),
      .fuses_o (fuses)
   );

   fuse_read_port #(
      .TOTAL(TOTAL), .AW(AW), .ID_LO(ID_BASE), .ID_HI(DIR_BASE), .ID_IS_OPEN(1'b1)
   ) u_read (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_en_i     (rd_en_i),
      .rd_addr_i   (rd_addr_i),
      .fuses_i     (fuses),
      .secured_i   (secured_o),
      .rd_data_o   (rd_data_o),
      .rd_denied_o (rd_denied_o)
   );

   // One-way read lock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         secured_o <= 1'b0;
      else if (erase_i)
         secured_o <= 1'b0;
      else if (lock_i)
         secured_o <= 1'b1;
   end

   // Field decode
   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         assign and_fuses_o[r*COLS +: COLS] = fuses[r*COLS +: COLS];
         assign term_off_o[r]               = fuses[OFF_BASE + r];
      end
      for (genvar c = 0; c < CELLS; c++) begin : g_cell
         assign cell_pol_o[c] = fuses[POL_BASE + c];
         assign cell_dir_o[c] = fuses[DIR_BASE + c];
      end
   endgenerate

   assign user_id_o     = fuses[ID_BASE +: ID_BITS];
   assign global_mode_o = fuses[MODE_BASE +: 2];

   // R5
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (secured_o && !erase_i) |=> secured_o);

   // R9
   erase_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_i |=> (!secured_o && load_addr_o == '0 && checksum_o == '0));

   // R8
   done_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_done_o && !erase_i) |=> ($stable(checksum_o) && load_done_o));

endmodule

// File: tb/tb_fusemap_cfg_store.sv
module tb_fusemap_cfg_store;

   localparam int CLK_PERIOD = 10;
   localparam int TOTAL      = 2194;
   localparam int ID_LO      = 2056;
   localparam int ID_HI      = 2120;
   localparam int WATCHDOG   = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          erase_i = 1'b0, load_en_i = 1'b0, load_bit_i = 1'b0;
   logic          lock_i = 1'b0, rd_en_i = 1'b0;
   logic [11:0]   rd_addr_i = '0;
   logic [11:0]   load_addr_o;
   logic          load_done_o;
   logic [15:0]   checksum_o;
   logic          rd_data_o, rd_denied_o, secured_o;
   logic [2047:0] and_fuses_o;
   logic [7:0]    cell_pol_o, cell_dir_o;
   logic [63:0]   term_off_o;
   logic [1:0]    global_mode_o;
   logic [63:0]   user_id_o;

   fusemap_cfg_store dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   // Behavioural reference
   bit          m_fuse[TOTAL];
   int          m_addr;
   int unsigned m_sum;
   bit          m_lock;
   bit          m_rd;
   bit          m_den;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [63:0] m_slice(input int base, input int width);
      logic [63:0] v = '0;
      for (int i = 0; i < width; i++) v[i] = m_fuse[base + i];
      return v;
   endfunction

   task automatic model_edge();
      int a = int'(rd_addr_i);
      if (rd_en_i) begin
         if (a >= TOTAL) begin m_rd = 0; m_den = 0; end
         else if (m_lock && !(a >= ID_LO && a < ID_HI)) begin m_rd = 0; m_den = 1; end
         else begin m_rd = m_fuse[a]; m_den = 0; end
      end else m_den = 0;
      if (erase_i) begin
         foreach (m_fuse[i]) m_fuse[i] = 0;
         m_addr = 0; m_sum = 0; m_lock = 0;
      end else begin
         if (load_en_i && m_addr < TOTAL) begin
            m_fuse[m_addr] = load_bit_i;
            if (load_bit_i) m_sum = (m_sum + (32'd1 << (m_addr % 16))) % 65536;
            m_addr++;
         end
         if (lock_i) m_lock = 1;
      end
   endtask

   task automatic compare_all();
      chk("R2 load address", 64'(load_addr_o), 64'(m_addr));
      chk("R8 load done", 64'(load_done_o), 64'(m_addr == TOTAL));
      chk("R8 checksum", 64'(checksum_o), 64'(m_sum));
      chk("R5 lock state", 64'(secured_o), 64'(m_lock));
      chk("R4 read data", 64'(rd_data_o), 64'(m_rd));
      chk("R6 denied flag", 64'(rd_denied_o), 64'(m_den));
      for (int r = 0; r < 64; r++)
         chk("R3 array row", 64'(and_fuses_o[r*32 +: 32]), m_slice(32*r, 32));
      chk("R3 polarity", 64'(cell_pol_o), m_slice(2048, 8));
      chk("R3 user id", user_id_o, m_slice(2056, 64));
      chk("R3 direction", 64'(cell_dir_o), m_slice(2120, 8));
      chk("R3 term disable", term_off_o, m_slice(2128, 64));
      chk("R3 global mode", 64'(global_mode_o), m_slice(2192, 2));
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      erase_i = 0; load_en_i = 0; load_bit_i = 0; lock_i = 0; rd_en_i = 0;
   endtask

   function automatic bit pat(input int a, input int seed);
      return bit'((((a * 37 + seed) >> 2) ^ (a >> 5) ^ seed) & 1);
   endfunction

   task automatic load_run(input int from, input int upto, input int seed);
      for (int a = from; a < upto; a++) begin
         load_en_i = 1;
         load_bit_i = (seed < 0) ? 1'b1 : pat(a, seed);
         rd_en_i = 1;
         rd_addr_i = 12'((a * 13) % 2200);
         tick();
      end
      idle();
   endtask

   task automatic read_at(input int a);
      rd_en_i = 1; rd_addr_i = 12'(a);
      tick();
      rd_en_i = 0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
            finish_run();
         end
      end
   end

   initial begin
      foreach (m_fuse[i]) m_fuse[i] = 0;
      m_addr = 0; m_sum = 0; m_lock = 0; m_rd = 0; m_den = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset address", 64'(load_addr_o), 0);
      chk("R1 reset checksum", 64'(checksum_o), 0);
      chk("R1 reset lock", 64'(secured_o), 0);
      chk("R1 reset array", 64'(|and_fuses_o), 0);
      chk("R1 reset user id", user_id_o, 0);
      chk("R1 reset read", 64'({rd_data_o, rd_denied_o}), 0);
      rst_n = 1;
      tick();

      // R2 R3 R4 R8: full load with reads running alongside
      erase_i = 1; tick(); idle();
      load_run(0, TOTAL, 1);
      chk("R8 done after last bit", 64'(load_done_o), 1);
      // R2: loads after the end are ignored
      for (int k = 0; k < 5; k++) begin load_en_i = 1; load_bit_i = ~load_bit_i; tick(); end
      idle();
      chk("R2 address held at end", 64'(load_addr_o), 64'(TOTAL));

      // R4 read sweep across every field boundary and past the end
      for (int a = 0; a < 2200; a += 7) read_at(a);
      read_at(2055); read_at(2056); read_at(2119); read_at(2120);
      read_at(2193); read_at(2194); read_at(4095);

      // R5 R6 R7: lock after load
      lock_i = 1; tick(); idle();
      chk("R5 lock set", 64'(secured_o), 1);
      read_at(5);
      chk("R6 config read refused", 64'({rd_data_o, rd_denied_o}), 64'(2'b01));
      tick();
      chk("R6 refusal lasts one cycle", 64'(rd_denied_o), 0);
      for (int a = 2040; a < 2200; a++) read_at(a);
      for (int k = 0; k < 4; k++) read_at(ID_LO + 17 * k);
      for (int k = 0; k < 10; k++) begin load_en_i = 1; tick(); end
      idle();
      chk("R5 lock still set", 64'(secured_o), 1);

      // R9: erase collides with lock and load
      erase_i = 1; lock_i = 1; load_en_i = 1; load_bit_i = 1; tick(); idle();
      chk("R9 erase clears lock", 64'(secured_o), 0);
      chk("R9 erase clears address", 64'(load_addr_o), 0);
      chk("R9 erase clears checksum", 64'(checksum_o), 0);
      chk("R9 erase clears id", user_id_o, 0);

      // R8: all-ones image
      load_run(0, TOTAL, -1);
      chk("R8 all ones checksum", 64'(checksum_o), 64'h0000_0000_0000_FF7A);

      // R5 R6: lock set halfway through a load
      erase_i = 1; tick(); idle();
      load_run(0, 1000, 2);
      lock_i = 1; tick(); idle();
      load_run(1000, TOTAL, 2);
      chk("R5 lock survives loading", 64'(secured_o), 1);
      for (int a = 0; a < TOTAL; a += 11) read_at(a);
      read_at(ID_LO + 3);
      chk("R7 id read open", 64'(rd_denied_o), 0);

      repeat (3) tick();
      finish_run();
   end

endmodule